// File: doc/BRIEF.md
# Horizontal Sync Presence Detector and Timing Source Selector

This block decides whether a usable external horizontal sync is arriving, and chooses the horizontal and vertical sync that the rest of a video overlay pipeline runs from. It counts rising edges of the external horizontal sync inside a window measured in line-rate ticks, and compares the count with a threshold. The threshold is picked by a 4-bit one-hot code. The result is a presence flag, which sets as soon as the threshold is met and clears when a whole window passes without meeting it.

Alongside the detector, a free-running line and field generator runs from the same line tick. It produces an internal horizontal pulse for every line and a vertical pulse once per field. It supports two field lengths: 263 lines with every vertical pulse at a line start, or 262.5 lines, where every second vertical pulse lands half a line into the last line of the first field. The half-line point is derived from the measured tick period. A select input routes either the synchronised external pair or the internal pair to the outputs.

Top module: `sync_presence_sel`

## Requirements
- R1: Threshold codes 4'b0001, 4'b0010, 4'b0100 and 4'b1000 (bit i set) require 16, 32, 64 and 128 rising edges of `ext_hsync` respectively. `sync_present` rises when that count is reached within the current window and stays low while the count is one short.
- R2: A window lasts WIN_MULT (default 2) times the threshold in `line_tick` pulses. `sync_present` stays high until a complete window ends without the threshold being reached, and then goes low.
- R3: Code 4'b0000, and any code that is not one-hot, disables detection. `sync_present` is low one clock after such a code is registered, and edges are not counted.
- R4: Any change of the threshold code clears `sync_present` and restarts the window with a zero count.
- R5: With `int_sel` low, `hsync_out` and `vsync_out` follow `ext_hsync` and `ext_vsync` through a two-flop synchroniser. With `int_sel` high, the external inputs have no effect on the outputs.
- R6: The internal horizontal sync is a one-clock pulse in the clock after each `line_tick`.
- R7: With `nonint_sel` high, the internal vertical pulse comes every 263 lines and coincides with a line-start horizontal pulse.
- R8: With `nonint_sel` low, vertical pulses alternate. One comes at a line start after 263 horizontal pulses. The other comes after 262 horizontal pulses, half the measured tick period (in clocks) after the last of them, giving 262.5 lines per field.
- R9: While `rst_n` is low, the registered threshold code, source select and interlace select are zero, and `sync_present`, `hsync_out` and `vsync_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_hsync | input | 1 | External horizontal sync, active high |
| ext_vsync | input | 1 | External vertical sync, active high |
| line_tick | input | 1 | One-clock pulse at line rate |
| thr_code | input | 4 | One-hot detection threshold select |
| int_sel | input | 1 | 1: internal timing drives outputs, 0: external |
| nonint_sel | input | 1 | 1: 263-line fields, 0: 262.5-line fields |
| sync_present | output | 1 | External horizontal sync judged present |
| hsync_out | output | 1 | Selected horizontal sync |
| vsync_out | output | 1 | Selected vertical sync |

## Verification
The assertions assume that `line_tick` pulses are isolated single clocks with a steady spacing of at least two clocks. Without that, the internal horizontal pulse would merge across ticks and the half-line point would be undefined. They also assume that the external pulses last at least two clocks, so that each edge survives the synchroniser. The stimulus produces ticks from one fixed 16-clock divider and places every external pulse two clocks wide, well away from the tick. It changes mode selects only between measurements and discards the first field after each switch.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic [CODE_W-1:0] thr;
    logic              int_sel;
    logic              nonint;
  } sps_cfg_t;

  // A threshold code is usable only with exactly one bit set.
  function automatic logic code_ok(input logic [CODE_W-1:0] code);
    return $countones(code) == 1;
  endfunction

  // Bit i selects base << i edges; zero when no bit is set.
  function automatic int unsigned thr_of(input logic [CODE_W-1:0] code,
                                         input int unsigned base);
    int unsigned t;
    t = 0;
    for (int i = 0; i < CODE_W; i++) begin
      if (code[i]) t = base << i;
    end
    return t;
  endfunction

  // Last line index before the line counter wraps.
  function automatic int unsigned wrap_line(input logic nonint,
                                            input int unsigned field_lines);
    return nonint ? field_lines - 1 : 2 * field_lines - 2;
  endfunction
endpackage

// File: rtl/sps_sync_stage.sv
`timescale 1ns/1ps
module sps_sync_stage #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sps_presence_det.sv
`timescale 1ns/1ps
module sps_presence_det
  import sps_pkg::*;
#(
  parameter int BASE_PULSES = 16,
  parameter int WIN_MULT    = 2,
  parameter int CNT_W       = 8,
  parameter int WIN_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] thr_code,
  input  logic              code_chg,
  input  logic              line_tick,
  input  logic              hs_rise,
  output logic              present,
  output logic              hit,
  output logic              win_end,
  output logic              reached
);
  logic [CNT_W-1:0] pulse_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] thr;
  logic [WIN_W-1:0] win_len;
  logic             code_valid;

  assign code_valid = code_ok(thr_code);
  assign thr        = CNT_W'(thr_of(thr_code, BASE_PULSES));
  assign win_len    = WIN_W'(WIN_MULT * thr_of(thr_code, BASE_PULSES));

  assign reached = code_valid && (pulse_cnt >= thr);
  assign hit     = code_valid && hs_rise && !reached &&
                   (pulse_cnt == thr - CNT_W'(1));
  assign win_end = code_valid && line_tick &&
                   (win_cnt == win_len - WIN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_cnt <= '0;
      win_cnt   <= '0;
      present   <= 1'b0;
    end else if (!code_valid || code_chg) begin
      pulse_cnt <= '0;
      win_cnt   <= '0;
      present   <= 1'b0;
    end else if (win_end) begin
      pulse_cnt <= '0;
      win_cnt   <= '0;
      present   <= hit || reached;
    end else begin
      if (line_tick)            win_cnt   <= win_cnt + WIN_W'(1);
      if (hs_rise && !reached)  pulse_cnt <= pulse_cnt + CNT_W'(1);
      if (hit)                  present   <= 1'b1;
    end
  end
endmodule

// File: rtl/sps_line_gen.sv
`timescale 1ns/1ps
module sps_line_gen
  import sps_pkg::*;
#(
  parameter int FIELD_LINES = 263,
  parameter int LINE_W      = 10,
  parameter int PERIOD_W    = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_tick,
  input  logic nonint,
  output logic hs,
  output logic vs,
  output logic mid_vs,
  output logic line_zero
);
  logic [LINE_W-1:0]   line_cnt;
  logic [LINE_W-1:0]   wrap_at;
  logic [PERIOD_W-1:0] phase;
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] half;
  logic                seen;
  logic                per_ok;
  logic                at_wrap;

  assign wrap_at   = LINE_W'(wrap_line(nonint, FIELD_LINES));
  assign at_wrap   = (line_cnt >= wrap_at);
  assign half      = period_q >> 1;
  assign line_zero = (line_cnt == '0);

  // Half-line event on the last line of the first field (262.5-line mode).
  assign mid_vs = !nonint && per_ok && !line_tick &&
                  (line_cnt == LINE_W'(FIELD_LINES - 1)) &&
                  (half != '0) && (phase == half - PERIOD_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      phase    <= '0;
      period_q <= '0;
      seen     <= 1'b0;
      per_ok   <= 1'b0;
      hs       <= 1'b0;
      vs       <= 1'b0;
    end else if (line_tick) begin
      line_cnt <= at_wrap ? '0 : line_cnt + LINE_W'(1);
      vs       <= at_wrap;
      hs       <= 1'b1;
      phase    <= '0;
      seen     <= 1'b1;
      if (seen) begin
        period_q <= (phase == '1) ? phase : phase + PERIOD_W'(1);
        per_ok   <= 1'b1;
      end
    end else begin
      hs <= 1'b0;
      vs <= mid_vs;
      if (phase != '1) phase <= phase + PERIOD_W'(1);
    end
  end
endmodule

// File: rtl/sync_presence_sel.sv
`timescale 1ns/1ps
module sync_presence_sel
  import sps_pkg::*;
#(
  parameter int BASE_PULSES = 16,
  parameter int WIN_MULT    = 2,
  parameter int FIELD_LINES = 263,
  parameter int PERIOD_W    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_hsync,
  input  logic       ext_vsync,
  input  logic       line_tick,
  input  logic [3:0] thr_code,
  input  logic       int_sel,
  input  logic       nonint_sel,
  output logic       sync_present,
  output logic       hsync_out,
  output logic       vsync_out
);
  localparam int THR_MAX = BASE_PULSES << (CODE_W - 1);
  localparam int WIN_MAX = WIN_MULT * THR_MAX;
  localparam int CNT_W   = $clog2(THR_MAX + 1);
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int LINE_W  = $clog2(2 * FIELD_LINES);

  sps_cfg_t          cfg_q;
  logic [CODE_W-1:0] cfg_thr;
  logic              cfg_int;
  logic              cfg_nonint;
  logic              code_chg;
  logic              hs_s, vs_s, hs_prev, hs_rise;
  logic              int_hs, int_vs, mid_vs, line_zero;
  logic              det_hit, det_win_end, det_reached;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= '{thr: thr_code, int_sel: int_sel, nonint: nonint_sel};
  end

  assign cfg_thr    = cfg_q.thr;
  assign cfg_int    = cfg_q.int_sel;
  assign cfg_nonint = cfg_q.nonint;
  assign code_chg   = (thr_code != cfg_thr);

  sps_sync_stage #(.STAGES(SYNC_STAGES)) u_hs_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_hsync), .q(hs_s));
  sps_sync_stage #(.STAGES(SYNC_STAGES)) u_vs_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_vsync), .q(vs_s));

  always_ff @(posedge clk) begin
    if (!rst_n) hs_prev <= 1'b0;
    else        hs_prev <= hs_s;
  end
  assign hs_rise = hs_s && !hs_prev;

  sps_presence_det #(
    .BASE_PULSES(BASE_PULSES), .WIN_MULT(WIN_MULT),
    .CNT_W(CNT_W), .WIN_W(WIN_W)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .thr_code(cfg_thr), .code_chg(code_chg),
    .line_tick(line_tick), .hs_rise(hs_rise), .present(sync_present),
    .hit(det_hit), .win_end(det_win_end), .reached(det_reached));

  sps_line_gen #(
    .FIELD_LINES(FIELD_LINES), .LINE_W(LINE_W), .PERIOD_W(PERIOD_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .nonint(cfg_nonint),
    .hs(int_hs), .vs(int_vs), .mid_vs(mid_vs), .line_zero(line_zero));

  assign hsync_out = cfg_int ? int_hs : hs_s;
  assign vsync_out = cfg_int ? int_vs : vs_s;
endmodule

// File: rtl/sps_sync_chk.sv
`timescale 1ns/1ps
module sps_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] thr_q,
  input logic       code_chg,
  input logic       nonint_q,
  input logic       line_tick,
  input logic       int_hs,
  input logic       int_vs,
  input logic       line_zero,
  input logic       sync_present,
  input logic       det_hit,
  input logic       det_win_end,
  input logic       det_reached
);
  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_present) |-> $past(det_hit)); // R1

  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_present) |-> $past(det_win_end && !det_reached) ||
                            $past(code_chg) || $past($countones(thr_q) != 1)); // R2

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(thr_q) != 1) |=> !sync_present); // R3

  AST_CODE_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |=> !sync_present); // R4

  AST_HS_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> int_hs); // R6

  AST_HS_ONLY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> !int_hs); // R6

  AST_LINE_VS_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_vs && int_hs) |-> line_zero); // R7

  AST_MID_VS_INTERLACED: assert property (@(posedge clk) disable iff (!rst_n)
    (int_vs && !int_hs) |-> $past(!nonint_q)); // R8
endmodule

bind sync_presence_sel sps_sync_chk u_sps_chk (
  .clk(clk), .rst_n(rst_n), .thr_q(cfg_thr), .code_chg(code_chg),
  .nonint_q(cfg_nonint), .line_tick(line_tick), .int_hs(int_hs),
  .int_vs(int_vs), .line_zero(line_zero), .sync_present(sync_present),
  .det_hit(det_hit), .det_win_end(det_win_end), .det_reached(det_reached));

// File: tb/test_sync_presence_sel.sv
`timescale 1ns/1ps
module test_sync_presence_sel;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_hsync = 1'b0;
  logic       ext_vsync = 1'b0;
  logic       line_tick = 1'b0;
  logic [3:0] thr_code = 4'b0000;
  logic       int_sel = 1'b0;
  logic       nonint_sel = 1'b0;
  wire        sync_present, hsync_out, vsync_out;

  int  nchk = 0;
  int  nerr = 0;
  int  div = 0;
  bit  tick_en = 1'b0;

  typedef struct { int hs; int off; } item_t;
  item_t exp_q[$];
  bit    mon_en = 1'b0;
  int    hs_cnt = 0;
  int    since = 0;
  int    last_off = -1;
  event  vs_ev;

  always #2.5 clk = ~clk;

  sync_presence_sel i_sync_presence_sel (
    .clk(clk), .rst_n(rst_n), .ext_hsync(ext_hsync), .ext_vsync(ext_vsync),
    .line_tick(line_tick), .thr_code(thr_code), .int_sel(int_sel),
    .nonint_sel(nonint_sel), .sync_present(sync_present),
    .hsync_out(hsync_out), .vsync_out(vsync_out));

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  // Line tick source: one clock high every P clocks.
  initial begin
    forever begin
      @(negedge clk);
      div = (div == P - 1) ? 0 : div + 1;
      line_tick = tick_en && (div == P - 1);
    end
  end

  // Monitor: counts internal-path pulses and pops expected field items.
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hsync_out) begin hs_cnt++; since = 0; end
        else since++;
        if (vsync_out) begin
          last_off = since;
          if (mon_en && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(e.off == 0 ? "R7/R8 line-start field length" : "R8 half-line field length",
                  hs_cnt, e.hs);
            check(e.off == 0 ? "R7/R8 line-start offset" : "R8 half-line offset",
                  since, e.off);
          end
          hs_cnt = 0;
          ->vs_ev;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_pulse();
    do @(negedge clk); while (div != 4);
    ext_hsync = 1'b1;
    wait_clks(2);
    ext_hsync = 1'b0;
  endtask

  task automatic pulses(input int n, input int gap_lines);
    for (int i = 0; i < n; i++) begin
      ext_pulse();
      if (gap_lines > 1) wait_clks((gap_lines - 1) * P);
    end
  endtask

  task automatic push(input int hs, input int off);
    item_t it;
    it.hs = hs; it.off = off;
    exp_q.push_back(it);
  endtask

  initial begin
    // R9: reset holds everything low while inputs are active
    thr_code = 4'b0001; int_sel = 1'b1; nonint_sel = 1'b1; tick_en = 1'b1;
    ext_vsync = 1'b1;
    pulses(3, 1);
    check("R9 present in reset", sync_present, 0);
    check("R9 hsync_out in reset", hsync_out, 0);
    check("R9 vsync_out in reset", vsync_out, 0);
    thr_code = 4'b0000; int_sel = 1'b0; nonint_sel = 1'b0; ext_vsync = 1'b0;
    wait_clks(2);
    rst_n = 1'b1;
    wait_clks(3);
    check("R9 present after reset", sync_present, 0);

    // R1: each one-hot code, one edge short and exactly at threshold
    for (int k = 0; k < 4; k++) begin
      thr_code = 4'b0000;
      wait_clks(2 * P);
      check("R3 disabled code clears present", sync_present, 0);
      thr_code = 4'(1 << k);
      pulses((16 << k) - 1, 1);
      wait_clks(6);
      check("R1 one edge short", sync_present, 0);
      pulses(1, 1);
      wait_clks(6);
      check("R1 threshold reached", sync_present, 1);
    end

    // R2: holds during window, clears after a silent full window
    wait_clks(2 * P);
    check("R2 present held inside window", sync_present, 1);
    wait_clks(520 * P);
    check("R2 cleared after empty window", sync_present, 0);

    // R2: rate too low for a 32-line window at threshold 16
    thr_code = 4'b0001;
    pulses(40, 3);
    check("R2 sparse edges never present", sync_present, 0);

    // R4: code change clears present
    thr_code = 4'b0010; wait_clks(3); thr_code = 4'b0001;
    pulses(16, 1);
    wait_clks(6);
    check("R4 setup present", sync_present, 1);
    thr_code = 4'b0010;
    wait_clks(3);
    check("R4 code change clears", sync_present, 0);

    // R3: non-one-hot and zero codes ignore edges
    thr_code = 4'b0011;
    pulses(40, 1);
    wait_clks(6);
    check("R3 code 0011 ignored", sync_present, 0);
    thr_code = 4'b0000;
    pulses(40, 1);
    wait_clks(6);
    check("R3 code 0000 ignored", sync_present, 0);

    // R5: external path passes through, internal path ignores it
    int_sel = 1'b0;
    wait_clks(3);
    ext_hsync = 1'b1; ext_vsync = 1'b1;
    wait_clks(4);
    check("R5 ext hsync passes", hsync_out, 1);
    check("R5 ext vsync passes", vsync_out, 1);
    ext_hsync = 1'b0; ext_vsync = 1'b0;
    wait_clks(4);
    check("R5 ext hsync low passes", hsync_out, 0);
    check("R5 ext vsync low passes", vsync_out, 0);
    int_sel = 1'b1;
    ext_hsync = 1'b1;
    do @(negedge clk); while (div != 8);
    check("R5 ext hsync ignored when internal", hsync_out, 0);
    ext_hsync = 1'b0;

    // R6: internal hsync one clock after tick, one clock wide
    do @(negedge clk); while (!line_tick);
    @(negedge clk);
    check("R6 hsync after tick", hsync_out, 1);
    @(negedge clk);
    check("R6 hsync one clock wide", hsync_out, 0);

    // R7: 263-line fields
    nonint_sel = 1'b1;
    @(vs_ev);
    push(263, 0); push(263, 0);
    mon_en = 1'b1;
    wait (exp_q.size() == 0);
    mon_en = 1'b0;

    // R8: alternating 262.5-line fields
    nonint_sel = 1'b0;
    do @(vs_ev); while (last_off != 0);
    push(262, P / 2); push(263, 0); push(262, P / 2); push(263, 0);
    mon_en = 1'b1;
    wait (exp_q.size() == 0);
    mon_en = 1'b0;

    wait_clks(4);
    finish_run();
  end
endmodule